// File: doc/BRIEF.md
# Bidirectional Tick-Driven Counter

This block is the counting core of a general-purpose timer. An 8-bit count register advances once for each qualified timer tick. A tick is qualified when the tick-enable input is high and the clock-select field is nonzero; the divider that produces the ticks sits outside the block. A 2-bit waveform-mode field chooses one of four counting sequences:

- free-running wrap;
- up/down bounce;
- clear on a compare match;
- wrap with an early overflow flag.

The mode also decides which value counts as TOP.

Software can load the count at any time, whether or not the timer is running, and the load takes precedence over counting and clearing in that cycle. The block exports TOP and BOTTOM indications for downstream waveform logic. It also holds an overflow flag that software clears by writing a one to it.

Top module: `updown_tick_counter`

## Requirements
- R1: Reset sets the count to 0x00, clears the overflow flag and sets the counting direction to up. After reset, the first tick in bounce mode moves the count from 0x00 to 0x01.
- R2: While the clock select is 0, the count and the overflow flag hold, even when the tick input is high.
- R3: A load request puts the write data into the count on the next edge. This happens whether or not the timer runs, and it replaces any count or clear in that cycle, so that tick sets no overflow.
- R4: Mode 0 (waveMode=2'b00) counts up and wraps from 0xFF to 0x00. The overflow flag sets on the tick that wraps, and a full 256-tick revolution sets it exactly once.
- R5: Mode 1 (waveMode=2'b01) counts up to 0xFF and then reverses, so the tick at 0xFF gives 0xFE. Counting down, the tick at 0x00 gives 0x01 and sets the overflow flag.
- R6: Mode 2 (waveMode=2'b10) counts up and clears to 0x00 on the tick taken while the count equals the compare value. In this mode TOP is the compare value.
- R7: Mode 3 (waveMode=2'b11) counts up and wraps like mode 0, but the overflow flag sets on the tick that brings the count to 0xFF.
- R8: A one on the flag-clear input clears the overflow flag on the next edge. When a hardware set happens in the same cycle, the flag ends up set.
- R9: atTop is high while the count equals TOP, which is the compare value in mode 2 and 0xFF in the other modes. atBottom is high while the count is 0x00.
- R10: With the clock select nonzero but the tick input low, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Prescaled tick enable, one cycle wide |
| clkSel | input | 3 | Clock select; 0 stops the counter |
| waveMode | input | 2 | Counting sequence select |
| cmpVal | input | 8 | Compare value, used as TOP in mode 2 |
| cntWrEn | input | 1 | Software load strobe for the count |
| cntWrData | input | 8 | Value to load into the count |
| ovfClr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| count | output | 8 | Current count |
| atTop | output | 1 | Count equals TOP for the current mode |
| atBottom | output | 1 | Count equals 0x00 |
| ovfFlag | output | 1 | Overflow flag |

## Verification
The only hidden state is the direction bit of bounce mode. If it is wrong, the next qualified tick moves the count the wrong way, so the error is visible on `count` one edge later. Faults in the count or in the flag show up directly on `count`, `ovfFlag`, `atTop` or `atBottom` at the edge that follows the tick. The bench therefore checks every output after every edge it drives, and it places the turning points, the compare match and the write-versus-count collisions so that each fault lands on a sampled cycle.

// File: rtl/updown_cnt_pkg.sv
package updown_cnt_pkg;

  typedef enum logic [1:0] {
    MODE_WRAP      = 2'b00,
    MODE_BOUNCE    = 2'b01,
    MODE_MATCHCLR  = 2'b10,
    MODE_EARLYFLAG = 2'b11
  } waveMode_e;

  // strobes from control to datapath, at most one of incr/decr/clear high
  typedef struct packed {
    logic load;
    logic clear;
    logic incr;
    logic decr;
    logic setOvf;
  } cntCtrl_s;

endpackage

// File: rtl/updown_cnt_ctl.sv
module updown_cnt_ctl
  import updown_cnt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CS_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [CS_W-1:0]  clkSel,
  input  logic [1:0]       waveMode,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] count,
  output cntCtrl_s         ctrlStb,
  output logic             atTop,
  output logic             atBottom
);

  localparam logic [CNT_W-1:0] MAX_V  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MAX_M1 = MAX_V - 1'b1;
  localparam logic [CNT_W-1:0] BOT_V  = '0;

  logic dirDown, dirNext;
  logic tickQual, advance;
  logic [CNT_W-1:0] topVal;
  waveMode_e modeSel;

  assign modeSel  = waveMode_e'(waveMode);
  assign tickQual = tickEn && (clkSel != '0);
  assign advance  = tickQual && !cntWrEn;

  always_comb begin
    ctrlStb      = '0;
    ctrlStb.load = cntWrEn;
    dirNext      = dirDown;
    if (advance) begin
      unique case (modeSel)
        MODE_WRAP: begin
          dirNext        = 1'b0;
          ctrlStb.incr   = 1'b1;
          ctrlStb.setOvf = (count == MAX_V);
        end
        MODE_BOUNCE: begin
          if (dirDown) begin
            if (count == BOT_V) begin
              ctrlStb.incr   = 1'b1;
              ctrlStb.setOvf = 1'b1;
              dirNext        = 1'b0;
            end else begin
              ctrlStb.decr = 1'b1;
            end
          end else if (count == MAX_V) begin
            ctrlStb.decr = 1'b1;
            dirNext      = 1'b1;
          end else begin
            ctrlStb.incr = 1'b1;
          end
        end
        MODE_MATCHCLR: begin
          dirNext = 1'b0;
          if (count == cmpVal) ctrlStb.clear = 1'b1;
          else                 ctrlStb.incr  = 1'b1;
          ctrlStb.setOvf = (count == MAX_V);
        end
        MODE_EARLYFLAG: begin
          dirNext        = 1'b0;
          ctrlStb.incr   = 1'b1;
          ctrlStb.setOvf = (count == MAX_M1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirDown <= 1'b0;
    else       dirDown <= dirNext;
  end

  assign topVal   = (modeSel == MODE_MATCHCLR) ? cmpVal : MAX_V;
  assign atTop    = (count == topVal);
  assign atBottom = (count == BOT_V);

  // R5: reaching MAX while rising in bounce mode turns the direction
  a_r5_turn_down: assert property (@(posedge clk) disable iff (!rstN)
    (advance && modeSel == MODE_BOUNCE && !dirDown && count == MAX_V) |=> dirDown);

  // R5: leaving BOTTOM while falling turns back up
  a_r5_turn_up: assert property (@(posedge clk) disable iff (!rstN)
    (advance && modeSel == MODE_BOUNCE && dirDown && count == BOT_V) |=> !dirDown);

  // R2: no count strobe while stopped
  a_r2_stopped_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == '0) |-> !(ctrlStb.incr || ctrlStb.decr || ctrlStb.clear || ctrlStb.setOvf));

endmodule

// File: rtl/updown_cnt_dp.sv
module updown_cnt_dp
  import updown_cnt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtrl_s         ctrlStb,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag
);

  logic [CNT_W-1:0] countNext;

  always_comb begin
    countNext = count;
    if (ctrlStb.load)       countNext = cntWrData;
    else if (ctrlStb.clear) countNext = '0;
    else if (ctrlStb.incr)  countNext = count + 1'b1;
    else if (ctrlStb.decr)  countNext = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      count <= countNext;
      if (ctrlStb.setOvf) ovfFlag <= 1'b1;
      else if (ovfClr)    ovfFlag <= 1'b0;
    end
  end

  // R8: a hardware set always leaves the flag high
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.setOvf |=> ovfFlag);

  // R8: a clear with no set empties the flag
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && !ctrlStb.setOvf) |=> !ovfFlag);

endmodule

// File: rtl/updown_tick_counter.sv
module updown_tick_counter
  import updown_cnt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CS_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [CS_W-1:0]  clkSel,
  input  logic [1:0]       waveMode,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] count,
  output logic             atTop,
  output logic             atBottom,
  output logic             ovfFlag
);

  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

  cntCtrl_s ctrlStb;

  updown_cnt_ctl #(.CNT_W(CNT_W), .CS_W(CS_W)) u_ctl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .clkSel(clkSel),
    .waveMode(waveMode), .cmpVal(cmpVal), .cntWrEn(cntWrEn),
    .count(count), .ctrlStb(ctrlStb), .atTop(atTop), .atBottom(atBottom)
  );

  updown_cnt_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlStb(ctrlStb), .cntWrData(cntWrData),
    .ovfClr(ovfClr), .count(count), .ovfFlag(ovfFlag)
  );

  // R2: a stopped counter keeps its value unless written
  a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == '0 && !cntWrEn) |=> $stable(count));

  // R3: software load wins over everything
  a_r3_write_load: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> (count == $past(cntWrData)));

  // R4: mode 0 wraps MAX to zero
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (waveMode == 2'b00 && tickEn && clkSel != '0 && !cntWrEn && count == MAX_V)
      |=> (count == '0 && ovfFlag));

  // R6: compare match in mode 2 clears the count
  a_r6_match_clear: assert property (@(posedge clk) disable iff (!rstN)
    (waveMode == 2'b10 && tickEn && clkSel != '0 && !cntWrEn && count == cmpVal)
      |=> (count == '0));

endmodule

// File: tb/updown_tick_counter_bench.sv
module updown_tick_counter_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [2:0] clkSel = '0;
  logic [1:0] waveMode = '0;
  logic [7:0] cmpVal = '0;
  logic       cntWrEn = 1'b0;
  logic [7:0] cntWrData = '0;
  logic       ovfClr = 1'b0;
  logic [7:0] count;
  logic       atTop, atBottom, ovfFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  updown_tick_counter u_updown_tick_counter (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .clkSel(clkSel),
    .waveMode(waveMode), .cmpVal(cmpVal), .cntWrEn(cntWrEn),
    .cntWrData(cntWrData), .ovfClr(ovfClr), .count(count),
    .atTop(atTop), .atBottom(atBottom), .ovfFlag(ovfFlag)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] mode;
    logic [2:0] cs;
    logic       tick;
    logic       wr;
    logic [7:0] wd;
    logic [7:0] cmp;
    logic       clr;
    logic [7:0] eCnt;
    logic       eOvf;
    logic       eTop;
    logic       eBot;
  } vec_t;

  localparam int NVEC = 26;
  // req, mode, cs, tick, wr, wd, cmp, clr, expected count, ovf, top, bottom
  localparam vec_t VEC [NVEC] = '{
    '{4'd3,  2'd0, 3'd1, 1'b1, 1'b1, 8'hFE, 8'h00, 1'b0, 8'hFE, 1'b0, 1'b0, 1'b0}, // R3 load
    '{4'd4,  2'd0, 3'd1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0}, // R4
    '{4'd4,  2'd0, 3'd1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1}, // R4 wrap
    '{4'd8,  2'd0, 3'd1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0}, // R8 clear
    '{4'd2,  2'd0, 3'd0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R2 stopped
    '{4'd10, 2'd0, 3'd1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R10 no tick
    '{4'd3,  2'd0, 3'd0, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0}, // R3 stopped load
    '{4'd3,  2'd0, 3'd1, 1'b1, 1'b1, 8'h10, 8'h00, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0}, // R3 beats wrap
    '{4'd7,  2'd3, 3'd1, 1'b0, 1'b1, 8'hFD, 8'h00, 1'b0, 8'hFD, 1'b0, 1'b0, 1'b0}, // R7
    '{4'd7,  2'd3, 3'd1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'hFE, 1'b0, 1'b0, 1'b0}, // R7
    '{4'd7,  2'd3, 3'd1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0}, // R7 early flag
    '{4'd7,  2'd3, 3'd1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1}, // R7 wrap no set
    '{4'd9,  2'd2, 3'd1, 1'b0, 1'b1, 8'h04, 8'h05, 1'b0, 8'h04, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd9,  2'd2, 3'd1, 1'b1, 1'b0, 8'h00, 8'h05, 1'b0, 8'h05, 1'b0, 1'b1, 1'b0}, // R9 top=cmp
    '{4'd6,  2'd2, 3'd1, 1'b1, 1'b0, 8'h00, 8'h05, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R6 match clear
    '{4'd6,  2'd2, 3'd1, 1'b1, 1'b0, 8'h00, 8'h05, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd5,  2'd1, 3'd1, 1'b0, 1'b1, 8'hFE, 8'h05, 1'b0, 8'hFE, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd5,  2'd1, 3'd1, 1'b1, 1'b0, 8'h00, 8'h05, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0}, // R5
    '{4'd5,  2'd1, 3'd1, 1'b1, 1'b0, 8'h00, 8'h05, 1'b0, 8'hFE, 1'b0, 1'b0, 1'b0}, // R5 turn down
    '{4'd5,  2'd1, 3'd1, 1'b1, 1'b0, 8'h00, 8'h05, 1'b0, 8'hFD, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd5,  2'd1, 3'd1, 1'b0, 1'b1, 8'h01, 8'h05, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd5,  2'd1, 3'd1, 1'b1, 1'b0, 8'h00, 8'h05, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R5
    '{4'd5,  2'd1, 3'd1, 1'b1, 1'b0, 8'h00, 8'h05, 1'b0, 8'h01, 1'b1, 1'b0, 1'b0}, // R5 bottom flag
    '{4'd8,  2'd1, 3'd1, 1'b1, 1'b0, 8'h00, 8'h05, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0}, // R8
    '{4'd8,  2'd0, 3'd1, 1'b0, 1'b1, 8'hFF, 8'h05, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0}, // R8 setup
    '{4'd8,  2'd0, 3'd1, 1'b1, 1'b0, 8'h00, 8'h05, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1}  // R8 set wins
  };

  task automatic check(input string tag, input logic [7:0] eCnt, input logic eOvf,
                       input logic eTop, input logic eBot);
    nChecks++;
    if (count !== eCnt || ovfFlag !== eOvf || atTop !== eTop || atBottom !== eBot) begin
      nFails++;
      $display("FAIL %s: cnt=%h ovf=%b top=%b bot=%b expected cnt=%h ovf=%b top=%b bot=%b",
               tag, count, ovfFlag, atTop, atBottom, eCnt, eOvf, eTop, eBot);
    end
  endtask

  task automatic idle();
    tickEn = 1'b0; cntWrEn = 1'b0; ovfClr = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; idle(); clkSel = '0; waveMode = '0;
    @(posedge clk); #2;
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run hung, expected completion");
    finishRun();
  end

  initial begin
    @(posedge clk); #2;
    check("R1 reset state", 8'h00, 1'b0, 1'b0, 1'b1);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      waveMode  = VEC[i].mode;  clkSel  = VEC[i].cs;  tickEn = VEC[i].tick;
      cntWrEn   = VEC[i].wr;    cntWrData = VEC[i].wd; cmpVal = VEC[i].cmp;
      ovfClr    = VEC[i].clr;
      @(posedge clk); #2;
      check($sformatf("R%0d vector %0d", VEC[i].req, i),
            VEC[i].eCnt, VEC[i].eOvf, VEC[i].eTop, VEC[i].eBot);
    end
    idle();

    // R1: reset in mid-run after bounce mode turned down; direction must return to up
    waveMode = 2'b01; clkSel = 3'd1; cntWrEn = 1'b1; cntWrData = 8'hFF; tickEn = 1'b0;
    @(posedge clk); #2;
    cntWrEn = 1'b0; tickEn = 1'b1;
    @(posedge clk); #2;  // now falling
    doReset();
    check("R1 reset mid-run", 8'h00, 1'b0, 1'b0, 1'b1);
    waveMode = 2'b01; clkSel = 3'd1; tickEn = 1'b1;
    @(posedge clk); #2;
    check("R1 direction up after reset", 8'h01, 1'b0, 1'b0, 1'b0);

    // R4: full revolution in mode 0, flag only on the 256th tick
    doReset();
    waveMode = 2'b00; clkSel = 3'd5; tickEn = 1'b1;
    for (int k = 1; k < 256; k++) @(posedge clk);
    #2;
    check("R4 255 ticks", 8'hFF, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #2;
    check("R4 256 ticks", 8'h00, 1'b1, 1'b0, 1'b1);

    // R6: compare at MAX behaves as TOP and flags on the MAX tick
    doReset();
    waveMode = 2'b10; cmpVal = 8'hFF; clkSel = 3'd2; cntWrEn = 1'b1; cntWrData = 8'hFF;
    @(posedge clk); #2;
    cntWrEn = 1'b0;
    check("R6 cmp at MAX top", 8'hFF, 1'b0, 1'b1, 1'b0);
    tickEn = 1'b1;
    @(posedge clk); #2;
    check("R6 cmp at MAX clear", 8'h00, 1'b1, 1'b0, 1'b1);
    idle();

    finishRun();
  end

endmodule